// File: doc/BRIEF.md
# I2S Slave Transmit Enable Sequencer

This block sits in the transmit path of an I2S slave and decides when words leave a transmit FIFO for the serial data line. Software sets or clears one enable bit. A four-state machine follows that bit, but it only moves between idle and transmitting through an intermediate state. That state lasts a fixed number of frames, counted on word-select edges. As a result, serial output starts and stops only on frame boundaries, never part way through a frame.

The word-select and bit clock come from an external master. Both are brought into the system clock domain through two-flop synchronisers, and their edges are detected on the synchronised copies. On each word-select edge at which the machine is transmitting, one FIFO word is loaded into a shift register and sent MSB first, one bit per bit-clock falling edge. If the FIFO is empty at that edge, a word of zeros is sent instead. Software can read back both the enable bit and the current state.

Top module: `i2s_txgate`

## Requirements
- R1: After reset the state reads 0 (standby), the enable bit reads 0, `sd_out` is 0 and `fifo_rd` is low.
- R2: Offset 0x04 holds the enable in bit 0, which can be written and read back. All other bits of 0x04 read as 0. Offset 0x08 reads the state in bits 1:0 with the encoding standby=0, arming=1, running=2, draining=3, and its upper bits read as 0.
- R3: With the enable set in standby, the state becomes arming within two clocks. It becomes running at the second synchronised WS falling edge seen while arming.
- R4: With the enable cleared while running, the state becomes draining. It becomes standby at the second synchronised WS falling edge seen while draining.
- R5: A change of the enable during arming or draining does not cut that state short. The enable is evaluated again only once the state has completed.
- R6: At every synchronised WS edge where the state after the edge is running or draining and the FIFO is not empty, exactly one single-cycle `fifo_rd` pulse is issued, and the head word is loaded for transmission.
- R7: At such an edge with the FIFO empty, no read is issued and the word sent is all zeros.
- R8: In standby and arming the FIFO is never read and `sd_out` stays 0, even when the FIFO holds data.
- R9: A loaded word appears MSB first. Its MSB is on `sd_out` right after the WS edge, and each following bit-clock falling edge moves to the next lower bit. Zeros follow the LSB.
- R10: WS and the bit clock each pass through two synchronising flops before their edges take effect. `sd_out` must not change within 1.5 clocks of a bit-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| ws_in | input | 1 | Word-select from external master |
| sck_in | input | 1 | Bit clock from external master |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| fifo_data | input | 16 | Transmit FIFO head word (valid when not empty) |
| fifo_rd | output | 1 | Single-cycle pop strobe to the FIFO |
| sd_out | output | 1 | Serial data output |

## Verification
Two events can land in the same clock: the cycle in which an intermediate state completes on a WS falling edge, and the cycle in which the shifter decides whether to pop the FIFO at that same edge. The bench provokes this on every frame boundary. It keeps data queued in the FIFO while toggling the enable at random between frames, including during arming and draining, and also drains the FIFO to empty. A bench model tracks the state from the WS edges it drives, which gives the expected word for each channel slot. The bench then compares the captured serial word, the status register and the running FIFO read count against that model, so that a pop issued one frame too early or too late shows up as a word mismatch.

// File: rtl/i2s_txgate_pkg.sv
package i2s_txgate_pkg;

  typedef enum logic [1:0] {
    TXG_IDLE  = 2'd0,
    TXG_ARM   = 2'd1,
    TXG_RUN   = 2'd2,
    TXG_DRAIN = 2'd3
  } txg_state_e;

  // The shifter may take a word only in these states.
  function automatic logic txg_tx_open(input txg_state_e st);
    return (st == TXG_RUN) || (st == TXG_DRAIN);
  endfunction

  // Intermediate states carry a frame counter.
  function automatic logic txg_is_pre(input txg_state_e st);
    return (st == TXG_ARM) || (st == TXG_DRAIN);
  endfunction

endpackage

// File: rtl/i2s_txgate_sync.sv
module i2s_txgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              lvl_w;

  assign lvl_w = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= lvl_w;
    end
  end

  assign fall_o = prev_q & ~lvl_w;
  assign edge_o = prev_q ^ lvl_w;
endmodule

// File: rtl/i2s_txgate_seq.sv
module i2s_txgate_seq
  import i2s_txgate_pkg::*;
#(
  parameter int PRE_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       ws_fall_i,
  output txg_state_e state_o,
  output txg_state_e state_nxt_o
);
  localparam int CNT_W = $clog2(PRE_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_FRAMES - 1);

  txg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_done_w;

  assign pre_done_w = txg_is_pre(state_q) && ws_fall_i && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      TXG_IDLE: if (en_i) begin
        state_d = TXG_ARM;
        cnt_d   = '0;
      end
      TXG_RUN: if (!en_i) begin
        state_d = TXG_DRAIN;
        cnt_d   = '0;
      end
      TXG_ARM, TXG_DRAIN: begin
        if (pre_done_w) begin
          state_d = (state_q == TXG_ARM) ? TXG_RUN : TXG_IDLE;
          cnt_d   = '0;
        end else if (ws_fall_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = TXG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o     = state_q;
  assign state_nxt_o = state_d;
endmodule

// File: rtl/i2s_txgate_shift.sv
module i2s_txgate_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ws_edge_i,
  input  logic              sck_fall_i,
  input  logic              tx_open_i,
  input  logic              fifo_empty_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic              sd_o
);
  logic [WORD_W-1:0] sh_q;
  logic              take_w;

  assign take_w = ws_edge_i & tx_open_i & ~fifo_empty_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (ws_edge_i) begin
      sh_q <= take_w ? fifo_data_i : '0;
    end else if (sck_fall_i) begin
      sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign fifo_rd_o = take_w;
  assign sd_o      = sh_q[WORD_W-1];
endmodule

// File: rtl/i2s_txgate.sv
module i2s_txgate
  import i2s_txgate_pkg::*;
#(
  parameter int          WORD_W     = 16,
  parameter int          REG_W      = 32,
  parameter int          ADDR_W     = 8,
  parameter int          PRE_FRAMES = 2,
  parameter int          SYNC_STG   = 2,
  parameter logic [7:0]  CTRL_OFF   = 8'h04,
  parameter logic [7:0]  STAT_OFF   = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ws_in,
  input  logic              sck_in,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic              sd_out
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  logic       en_q;
  logic       ws_fall_w, ws_edge_w, sck_fall_w;
  logic       unused_sck_edge;
  logic       unused_wdata;
  txg_state_e state_q, state_nxt;

  assign unused_wdata = ^reg_wdata[REG_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          en_q <= 1'b0;
    else if (reg_we && reg_addr == CTRL_A) en_q <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_A)      reg_rdata[0]   = en_q;
    else if (reg_addr == STAT_A) reg_rdata[1:0] = state_q;
  end

  i2s_txgate_sync #(.STAGES(SYNC_STG)) ws_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(ws_in),
    .fall_o(ws_fall_w), .edge_o(ws_edge_w)
  );

  i2s_txgate_sync #(.STAGES(SYNC_STG)) sck_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(sck_in),
    .fall_o(sck_fall_w), .edge_o(unused_sck_edge)
  );

  i2s_txgate_seq #(.PRE_FRAMES(PRE_FRAMES)) seq_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_q), .ws_fall_i(ws_fall_w),
    .state_o(state_q), .state_nxt_o(state_nxt)
  );

  i2s_txgate_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .ws_edge_i(ws_edge_w), .sck_fall_i(sck_fall_w),
    .tx_open_i(txg_tx_open(state_nxt)),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_rd_o(fifo_rd), .sd_o(sd_out)
  );
endmodule

// File: rtl/i2s_txgate_chk.sv
module i2s_txgate_chk
  import i2s_txgate_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_q,
  input logic       ws_fall_w,
  input logic       ws_edge_w,
  input logic       sck_fall_w,
  input logic       fifo_rd,
  input logic       fifo_empty,
  input logic       sd_out
);
  // R7
  rd_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  // R6
  rd_then_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> (state_q == TXG_RUN || state_q == TXG_DRAIN));

  // R3
  arm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == TXG_IDLE && state_q != TXG_IDLE) |-> state_q == TXG_ARM);

  // R4
  drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == TXG_RUN && state_q != TXG_RUN) |-> state_q == TXG_DRAIN);

  // R5
  pre_exit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state_q) == TXG_ARM || $past(state_q) == TXG_DRAIN) &&
     state_q != $past(state_q)) |-> $past(ws_fall_w));

  // R8
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TXG_IDLE || state_q == TXG_ARM) |-> !sd_out);

  // R9
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ws_edge_w) && !$past(sck_fall_w)) |-> $stable(sd_out));
endmodule

bind i2s_txgate i2s_txgate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state_q(state_q),
  .ws_fall_w(ws_fall_w), .ws_edge_w(ws_edge_w), .sck_fall_w(sck_fall_w),
  .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .sd_out(sd_out)
);

// File: tb/i2s_txgate_tb_top.sv
module i2s_txgate_tb_top;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ws_in = 1'b1;
  logic        sck_in = 1'b1;
  logic        fifo_rd, sd_out;
  logic [W-1:0] fmem [256];
  int          wp = 0;
  int          rp = 0;
  logic        fifo_empty;
  logic [W-1:0] fifo_data;

  int nchk = 0, nfail = 0;
  int m_st = 0, m_cnt = 0, m_rp = 0;
  logic m_en = 1'b0, prev_ws = 1'b1;

  always #5 clk = ~clk;

  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp[7:0]];
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  i2s_txgate dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ws_in(ws_in), .sck_in(sck_in),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd), .sd_out(sd_out)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_open(input int st);
    return (st == 2) || (st == 3);
  endfunction

  // Model: immediate moves out of the stable states.
  task automatic m_settle();
    if (m_st == 0 && m_en) begin m_st = 1; m_cnt = 0; end
    else if (m_st == 2 && !m_en) begin m_st = 3; m_cnt = 0; end
  endtask

  // Model: a WS falling edge while in an intermediate state.
  task automatic m_fall();
    if (m_st == 1 || m_st == 3) begin
      m_cnt++;
      if (m_cnt == 2) begin
        m_st  = (m_st == 1) ? 2 : 0;
        m_cnt = 0;
      end
    end
  endtask

  task automatic push(input logic [W-1:0] w);
    if (wp - rp < 200) begin
      fmem[wp[7:0]] = w;
      wp++;
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'h04) begin m_en = d[0]; m_settle(); end
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_en(input logic e);
    reg_write(8'h04, {31'd0, e});
  endtask

  // One bit-clock period: fall (with WS update), low, rise, sample.
  task automatic bit_cycle(input logic wsv, output logic early, output logic late);
    @(negedge clk);
    sck_in = 1'b0; ws_in = wsv;
    repeat (2) @(negedge clk);
    early = sd_out;
    repeat (2) @(negedge clk);
    sck_in = 1'b1;
    repeat (2) @(negedge clk);
    late = sd_out;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_word(input logic wsv, input string tag);
    logic [W-1:0] got, exp_w;
    logic early, late, prev_bit, lat_ok;
    logic [31:0] st;
    logic fall, edg;
    fall = prev_ws && !wsv;
    edg  = prev_ws != wsv;
    if (fall) m_fall();
    exp_w = '0;
    if (edg && m_open(m_st) && m_rp < wp) begin
      exp_w = fmem[m_rp[7:0]];
      m_rp++;
    end
    m_settle();
    prev_ws = wsv;
    lat_ok = 1'b1;
    prev_bit = 1'b0;
    for (int j = 0; j < W; j++) begin
      bit_cycle(wsv, early, late);
      if (j > 0 && early !== prev_bit) lat_ok = 1'b0;
      got[W-1-j] = late;
      prev_bit = late;
    end
    chk(got === exp_w, {tag, " word"}, {16'd0, got}, {16'd0, exp_w});
    chk(lat_ok, "R10 sync latency", {31'd0, lat_ok}, 32'd1);
    reg_read(8'h08, st);
    chk(st === m_st, {tag, " status"}, st, m_st);
    chk(rp === m_rp, {tag, " fifo reads"}, rp, m_rp);
  endtask

  task automatic run_frame(input string tag);
    run_word(1'b0, tag);
    run_word(1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog all requirements act=timeout exp=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    // R1 reset state
    reg_read(8'h08, d); chk(d === 32'd0, "R1 status", d, 0);
    reg_read(8'h04, d); chk(d === 32'd0, "R1 enable", d, 0);
    chk(sd_out === 1'b0 && fifo_rd === 1'b0, "R1 outputs", {30'd0, sd_out, fifo_rd}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 register map
    reg_write(8'h04, 32'hFFFF_FFFE);
    reg_read(8'h04, d); chk(d === 32'd0, "R2 upper bits", d, 0);
    reg_write(8'h04, 32'h0000_0000);
    reg_read(8'h08, d); chk(d === 32'd0, "R2 status idle", d, 0);

    // R8 data queued while standby: nothing read or sent
    push(16'hA5C3); push(16'h8001); push(16'hFFFF); push(16'h1234);
    repeat (3) run_frame("R8");

    // R3 enable: arming then running on second WS fall
    set_en(1'b1);
    reg_read(8'h04, d); chk(d === 32'd1, "R2 enable readback", d, 1);
    reg_read(8'h08, d); chk(d === 32'd1, "R3 arming", d, 1);
    repeat (3) run_frame("R3");
    // R6 R9 data flow, then R7 FIFO empty
    push(16'hAAAA); push(16'h5555);
    repeat (4) run_frame("R7");

    // R4 disable with data queued
    push(16'h0F0F); push(16'hF0F0); push(16'hC001); push(16'h7FFE);
    push(16'h1111); push(16'h2222);
    set_en(1'b0);
    reg_read(8'h08, d); chk(d === 32'd3, "R4 draining", d, 3);
    repeat (3) run_frame("R4");

    // R5 toggles inside intermediate states
    set_en(1'b1);
    run_frame("R5");
    set_en(1'b0);
    reg_read(8'h08, d); chk(d === 32'd1, "R5 arming holds", d, 1);
    repeat (3) run_frame("R5");
    set_en(1'b1);
    repeat (2) run_frame("R5");
    push(16'h3C3C);
    set_en(1'b0);
    run_frame("R5");
    set_en(1'b1);
    repeat (3) run_frame("R5");

    // Random mix: R6 R9
    for (int i = 0; i < 30; i++) begin
      int n;
      n = $urandom_range(0, 3);
      for (int k = 0; k < n; k++) push(W'($urandom));
      if ($urandom_range(0, 2) == 0) set_en(~m_en);
      run_frame("R6 R9 random");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule